// File: doc/BRIEF.md
# Decoupled Instruction Fetch Front End with Line-Stored Prediction

This block is the fetch stage of a wide in-order core. It holds a small on-chip array of fetch lines. Each line is 32 bytes and carries two 16-byte instruction bundles. The same line also holds a branch target, given as a line index, and a one-bit taken prediction. One line is read per clock. The registered read returns the instructions, the target and the prediction together. In the same cycle, combinational logic uses that prediction to choose the next fetch address. There is no separate prediction table, and no bubble follows a predicted-taken line.

Fetched bundles go into an eight-entry queue, each one tagged with its own byte address. The queue separates the fetch stage from the back end, which removes zero, one or two bundles per cycle. When the queue is nearly full, fetch stops and keeps its place. The back end can redirect fetch to any line. A redirect also flushes the queue. An update port lets the back end rewrite the target and prediction of a line once it has resolved a branch. A load port writes whole lines into the array.

Top module: `bfetch_frontend`

## Requirements
- R1: While `rst` is high, `q_count` is 0 and `fetch_addr` is 0. The first line fetched after reset is line 0.
- R2: In every cycle that is neither stalled nor redirected, both bundles of the line at `fetch_addr` are appended to the queue. Bundle 0 goes first and is tagged `fetch_addr`. Bundle 1 follows and is tagged `fetch_addr + 16`.
- R3: If the current line's stored prediction is not-taken, the next `fetch_addr` is the current one plus 32. It wraps modulo 2^ADDR_W, and the stored target has no effect.
- R4: If the current line's stored prediction is taken, the next `fetch_addr` is its stored target line index times 32.
- R5: Fetch stalls when `q_count` exceeds QDEPTH-2 at the start of a cycle. During a stall no bundle is appended and `fetch_addr` holds its value. The decision ignores any pops made in the same cycle.
- R6: `q_count` never exceeds QDEPTH.
- R7: `deq_num` requests a number of pops, with the value 3 treated as 2. The queue removes min(request, `q_count`) entries from the head. `head0_*` shows the oldest entry and `head1_*` the next oldest. `q_count` reflects each cycle's pushes and pops on the following cycle.
- R8: A `redir_valid` cycle has priority over stall and prediction. On the next cycle `q_count` is 0 and `fetch_addr` is `redir_line` times 32. Nothing is appended in the redirect cycle, whatever `deq_num` is.
- R9: An update writes `upd_target` and `upd_taken` into line `upd_line` and leaves that line's bundles unchanged. Later fetches of that line follow the new prediction.
- R10: A load writes both bundles, the target and the taken bit of line `ld_line`. The bundles seen at the queue head are exactly the loaded values for each tagged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write a whole line into the array |
| ld_line | input | ADDR_W-5 | Line index to load |
| ld_bundle0 | input | BUNDLE_W | First bundle of the loaded line |
| ld_bundle1 | input | BUNDLE_W | Second bundle of the loaded line |
| ld_target | input | ADDR_W-5 | Stored target line index |
| ld_taken | input | 1 | Stored taken prediction |
| upd_en | input | 1 | Rewrite the prediction fields of a line |
| upd_line | input | ADDR_W-5 | Line index to update |
| upd_target | input | ADDR_W-5 | New target line index |
| upd_taken | input | 1 | New taken prediction |
| redir_valid | input | 1 | Back-end redirect, flushes the queue |
| redir_line | input | ADDR_W-5 | Line index to fetch next on a redirect |
| deq_num | input | 2 | Bundles to pop this cycle (3 acts as 2) |
| fetch_addr | output | ADDR_W | Byte address of the line being fetched |
| q_count | output | $clog2(QDEPTH+1) | Bundles held in the queue |
| head0_addr | output | ADDR_W | Address of the oldest queued bundle |
| head0_bundle | output | BUNDLE_W | Oldest queued bundle |
| head1_addr | output | ADDR_W | Address of the second-oldest bundle |
| head1_bundle | output | BUNDLE_W | Second-oldest bundle |

## Verification
A wrong next-address choice appears on `fetch_addr` one cycle after the line that caused it. Every later bundle address in the queue inherits the error, so the bench compares the addresses against a model on every cycle. A corrupt queue pointer or count shows at `head0_addr`/`head1_addr` or `q_count` as soon as the affected entry reaches the head, which is at most four pops later. A stale prediction after an update shows only when the updated line is next fetched and the queue has space. The bench therefore holds fetch stalled across the update and then drains the queue to expose it.

// File: rtl/bfetch_pkg.sv
package bfetch_pkg;
  // log2 of bytes per fetch line (two bundles)
  localparam int LINE_SHIFT   = 5;
  // log2 of bytes per bundle
  localparam int BUNDLE_SHIFT = 4;

  typedef enum logic [2:0] {
    NXT_RESET,
    NXT_REDIRECT,
    NXT_HOLD,
    NXT_TARGET,
    NXT_SEQUENTIAL
  } nxt_src_e;
endpackage

// File: rtl/bfetch_line_store.sv
module bfetch_line_store #(
  parameter  int BUNDLE_W = 128,
  parameter  int LIDX_W   = 5,
  localparam int LINES    = 1 << LIDX_W
) (
  input  logic                clk,
  input  logic                ld_en,
  input  logic [LIDX_W-1:0]   ld_line,
  input  logic [BUNDLE_W-1:0] ld_bundle0,
  input  logic [BUNDLE_W-1:0] ld_bundle1,
  input  logic [LIDX_W-1:0]   ld_target,
  input  logic                ld_taken,
  input  logic                upd_en,
  input  logic [LIDX_W-1:0]   upd_line,
  input  logic [LIDX_W-1:0]   upd_target,
  input  logic                upd_taken,
  input  logic [LIDX_W-1:0]   rd_line,
  output logic [BUNDLE_W-1:0] rd_bundle0,
  output logic [BUNDLE_W-1:0] rd_bundle1,
  output logic [LIDX_W-1:0]   rd_target,
  output logic                rd_taken
);
  // instruction words: written only by the load port
  logic [2*BUNDLE_W-1:0] imem [LINES];
  // prediction fields {taken, target}: load and update share one write port
  logic [LIDX_W:0]       pmem [LINES];

  logic              pw_en;
  logic [LIDX_W-1:0] pw_addr;
  logic [LIDX_W:0]   pw_data;

  always_comb begin
    pw_en   = upd_en | ld_en;
    pw_addr = upd_en ? upd_line : ld_line;
    pw_data = upd_en ? {upd_taken, upd_target} : {ld_taken, ld_target};
  end

  always_ff @(posedge clk) begin
    if (ld_en) imem[ld_line] <= {ld_bundle1, ld_bundle0};
    {rd_bundle1, rd_bundle0} <= imem[rd_line];
  end

  always_ff @(posedge clk) begin
    if (pw_en) pmem[pw_addr] <= pw_data;
    {rd_taken, rd_target} <= pmem[rd_line];
  end
endmodule

// File: rtl/bfetch_next_addr.sv
module bfetch_next_addr import bfetch_pkg::*; #(
  parameter  int ADDR_W = 10,
  localparam int LIDX_W = ADDR_W - LINE_SHIFT
) (
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [LIDX_W-1:0] redir_line,
  input  logic              stall,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              line_taken,
  input  logic [LIDX_W-1:0] line_target,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(1 << LINE_SHIFT);

  nxt_src_e src;

  // priority: reset, redirect, stall, stored prediction, sequential
  always_comb begin
    if (rst)              src = NXT_RESET;
    else if (redir_valid) src = NXT_REDIRECT;
    else if (stall)       src = NXT_HOLD;
    else if (line_taken)  src = NXT_TARGET;
    else                  src = NXT_SEQUENTIAL;
  end

  always_comb begin
    unique case (src)
      NXT_RESET:    nxt_addr = '0;
      NXT_REDIRECT: nxt_addr = {redir_line, {LINE_SHIFT{1'b0}}};
      NXT_HOLD:     nxt_addr = cur_addr;
      NXT_TARGET:   nxt_addr = {line_target, {LINE_SHIFT{1'b0}}};
      default:      nxt_addr = cur_addr + LINE_STEP;
    endcase
  end
endmodule

// File: rtl/bfetch_bundle_queue.sv
module bfetch_bundle_queue #(
  parameter  int EW    = 138,
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [EW-1:0]    push_d0,
  input  logic [EW-1:0]    push_d1,
  input  logic [1:0]       pop_req,
  output logic [CNT_W-1:0] count,
  output logic [EW-1:0]    head0,
  output logic [EW-1:0]    head1
);
  logic [EW-1:0]    slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [1:0]       req_lim, pop_n;

  always_comb begin
    req_lim = (pop_req > 2'd2) ? 2'd2 : pop_req;
    pop_n   = (CNT_W'(req_lim) > count) ? count[1:0] : req_lim;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wr_ptr]               <= push_d0;
      slots[wr_ptr + PTR_W'(1)]   <= push_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(2);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      count  <= count + (push ? CNT_W'(2) : CNT_W'(0)) - CNT_W'(pop_n);
    end
  end

  assign head0 = slots[rd_ptr];
  assign head1 = slots[rd_ptr + PTR_W'(1)];
endmodule

// File: rtl/bfetch_frontend.sv
module bfetch_frontend import bfetch_pkg::*; #(
  parameter  int ADDR_W   = 10,
  parameter  int BUNDLE_W = 128,
  parameter  int QDEPTH   = 8,
  localparam int LIDX_W   = ADDR_W - LINE_SHIFT,
  localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_en,
  input  logic [LIDX_W-1:0]   ld_line,
  input  logic [BUNDLE_W-1:0] ld_bundle0,
  input  logic [BUNDLE_W-1:0] ld_bundle1,
  input  logic [LIDX_W-1:0]   ld_target,
  input  logic                ld_taken,
  input  logic                upd_en,
  input  logic [LIDX_W-1:0]   upd_line,
  input  logic [LIDX_W-1:0]   upd_target,
  input  logic                upd_taken,
  input  logic                redir_valid,
  input  logic [LIDX_W-1:0]   redir_line,
  input  logic [1:0]          deq_num,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic [CNT_W-1:0]    q_count,
  output logic [ADDR_W-1:0]   head0_addr,
  output logic [BUNDLE_W-1:0] head0_bundle,
  output logic [ADDR_W-1:0]   head1_addr,
  output logic [BUNDLE_W-1:0] head1_bundle
);
  localparam int EW = ADDR_W + BUNDLE_W;
  localparam logic [CNT_W-1:0] STALL_ABOVE = CNT_W'(QDEPTH - 2);

  logic [ADDR_W-1:0]   pc_q, pc_nxt;
  logic [BUNDLE_W-1:0] rd_bundle0, rd_bundle1;
  logic [LIDX_W-1:0]   rd_target;
  logic                rd_taken;
  logic                stall, push;
  logic [EW-1:0]       ent0, ent1, head0, head1;

  // line read is addressed by the address being selected, so the registered
  // data always belongs to pc_q and its prediction picks the following line
  bfetch_line_store #(.BUNDLE_W(BUNDLE_W), .LIDX_W(LIDX_W)) u_store (
    .clk        (clk),
    .ld_en      (ld_en),
    .ld_line    (ld_line),
    .ld_bundle0 (ld_bundle0),
    .ld_bundle1 (ld_bundle1),
    .ld_target  (ld_target),
    .ld_taken   (ld_taken),
    .upd_en     (upd_en),
    .upd_line   (upd_line),
    .upd_target (upd_target),
    .upd_taken  (upd_taken),
    .rd_line    (pc_nxt[ADDR_W-1:LINE_SHIFT]),
    .rd_bundle0 (rd_bundle0),
    .rd_bundle1 (rd_bundle1),
    .rd_target  (rd_target),
    .rd_taken   (rd_taken)
  );

  assign stall = q_count > STALL_ABOVE;
  assign push  = !rst && !stall && !redir_valid;

  bfetch_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .rst         (rst),
    .redir_valid (redir_valid),
    .redir_line  (redir_line),
    .stall       (stall),
    .cur_addr    (pc_q),
    .line_taken  (rd_taken),
    .line_target (rd_target),
    .nxt_addr    (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign ent0 = {pc_q, rd_bundle0};
  assign ent1 = {pc_q | ADDR_W'(1 << BUNDLE_SHIFT), rd_bundle1};

  bfetch_bundle_queue #(.EW(EW), .DEPTH(QDEPTH)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .flush   (redir_valid),
    .push    (push),
    .push_d0 (ent0),
    .push_d1 (ent1),
    .pop_req (deq_num),
    .count   (q_count),
    .head0   (head0),
    .head1   (head1)
  );

  assign fetch_addr = pc_q;
  assign {head0_addr, head0_bundle} = head0;
  assign {head1_addr, head1_bundle} = head1;
endmodule

// File: rtl/bfetch_frontend_chk.sv
module bfetch_frontend_chk #(
  parameter  int ADDR_W = 10,
  parameter  int QDEPTH = 8,
  localparam int LIDX_W = ADDR_W - 5,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              redir_valid,
  input logic [LIDX_W-1:0] redir_line,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [CNT_W-1:0]  q_count,
  input logic              line_taken,
  input logic [LIDX_W-1:0] line_target
);
  logic full_ish;
  assign full_ish = q_count > CNT_W'(QDEPTH - 2);

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(QDEPTH)); // R6

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> (q_count == '0 &&
                     fetch_addr == {$past(redir_line), 5'b0})); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!redir_valid && full_ish) |=>
      ($stable(fetch_addr) && q_count <= $past(q_count))); // R5

  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!redir_valid && !full_ish && !line_taken) |=>
      fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(32))); // R3

  AST_TAKEN_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!redir_valid && !full_ish && line_taken) |=>
      fetch_addr == {$past(line_target), 5'b0}); // R4
endmodule

bind bfetch_frontend bfetch_frontend_chk #(.ADDR_W(ADDR_W), .QDEPTH(QDEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .redir_valid (redir_valid),
  .redir_line  (redir_line),
  .fetch_addr  (fetch_addr),
  .q_count     (q_count),
  .line_taken  (rd_taken),
  .line_target (rd_target)
);

// File: tb/test_bfetch_frontend.sv
`timescale 1ns/1ps
module test_bfetch_frontend;
  localparam int AW = 10;
  localparam int BW = 128;
  localparam int QD = 8;
  localparam int LW = 5;
  localparam int NL = 32;
  localparam int NROWS = 34;

  // stimulus rows: {redirect, redirect line[4:0], deq_num[1:0]}
  // expected results come from the reference model below
  localparam logic [7:0] STIM [NROWS] = '{
    {1'b0,5'd0,2'd0}, {1'b0,5'd0,2'd0}, {1'b0,5'd0,2'd0},
    {1'b0,5'd0,2'd0}, {1'b0,5'd0,2'd0}, {1'b0,5'd0,2'd0},
    {1'b0,5'd0,2'd3}, {1'b0,5'd0,2'd1}, {1'b0,5'd0,2'd1},
    {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2},
    {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2},
    {1'b1,5'd12,2'd0},
    {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2},
    {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2},
    {1'b0,5'd0,2'd2}, {1'b0,5'd0,2'd2},
    {1'b1,5'd31,2'd0},
    {1'b0,5'd0,2'd1}, {1'b0,5'd0,2'd1}, {1'b0,5'd0,2'd1},
    {1'b0,5'd0,2'd1},
    {1'b1,5'd5,2'd2},
    {1'b0,5'd0,2'd0}, {1'b0,5'd0,2'd0}, {1'b0,5'd0,2'd0},
    {1'b0,5'd0,2'd0}
  };

  logic          clk, rst;
  logic          ld_en, ld_taken, upd_en, upd_taken, redir_valid;
  logic [LW-1:0] ld_line, ld_target, upd_line, upd_target, redir_line;
  logic [BW-1:0] ld_bundle0, ld_bundle1;
  logic [1:0]    deq_num;
  logic [AW-1:0] fetch_addr, head0_addr, head1_addr;
  logic [3:0]    q_count;
  logic [BW-1:0] head0_bundle, head1_bundle;

  bfetch_frontend #(.ADDR_W(AW), .BUNDLE_W(BW), .QDEPTH(QD)) i_bfetch_frontend (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_line(ld_line), .ld_bundle0(ld_bundle0),
    .ld_bundle1(ld_bundle1), .ld_target(ld_target), .ld_taken(ld_taken),
    .upd_en(upd_en), .upd_line(upd_line), .upd_target(upd_target),
    .upd_taken(upd_taken),
    .redir_valid(redir_valid), .redir_line(redir_line), .deq_num(deq_num),
    .fetch_addr(fetch_addr), .q_count(q_count),
    .head0_addr(head0_addr), .head0_bundle(head0_bundle),
    .head1_addr(head1_addr), .head1_bundle(head1_bundle)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  // reference model state
  int  m_tgt [NL];
  bit  m_tk  [NL];
  int  m_pc;
  int  mq [16];
  int  mcnt;

  function automatic logic [BW-1:0] bval(input int line, input int k);
    return {4{8'(line), 8'(k), 16'hBEEF}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(q_count == 4'(mcnt), "R7", "queue count", BW'(q_count), BW'(mcnt));
    chk(q_count <= 4'(QD), "R6", "count bound", BW'(q_count), BW'(QD));
    chk(int'(fetch_addr) == m_pc * 32, "R3 R4", "fetch address",
        BW'(fetch_addr), BW'(m_pc * 32));
    if (mcnt >= 1) begin
      chk(int'(head0_addr) == mq[0], "R2", "head0 address",
          BW'(head0_addr), BW'(mq[0]));
      chk(head0_bundle == bval(mq[0] >> 5, (mq[0] >> 4) & 1), "R10",
          "head0 bundle", head0_bundle, bval(mq[0] >> 5, (mq[0] >> 4) & 1));
    end
    if (mcnt >= 2) begin
      chk(int'(head1_addr) == mq[1], "R2", "head1 address",
          BW'(head1_addr), BW'(mq[1]));
      chk(head1_bundle == bval(mq[1] >> 5, (mq[1] >> 4) & 1), "R10",
          "head1 bundle", head1_bundle, bval(mq[1] >> 5, (mq[1] >> 4) & 1));
    end
  endtask

  task automatic model_step(input bit rv, input int rl, input int dq,
                            input bit ue, input int ul, input int ut, input bit utk);
    bit stall;
    int pop;
    stall = mcnt > QD - 2;
    pop = (dq > 2) ? 2 : dq;
    if (pop > mcnt) pop = mcnt;
    if (rv) begin
      mcnt = 0;
      m_pc = rl;
    end else begin
      for (int j = 0; j < mcnt - pop; j++) mq[j] = mq[j + pop];
      mcnt = mcnt - pop;
      if (!stall) begin
        mq[mcnt]     = m_pc * 32;
        mq[mcnt + 1] = m_pc * 32 + 16;
        mcnt = mcnt + 2;
        m_pc = m_tk[m_pc] ? m_tgt[m_pc] : (m_pc + 1) % NL;
      end
    end
    if (ue) begin
      m_tgt[ul] = ut;
      m_tk[ul]  = utk;
    end
  endtask

  // called at a falling edge: drive, advance model, wait one cycle, compare
  task automatic tick(input bit rv, input int rl, input int dq,
                      input bit ue = 1'b0, input int ul = 0,
                      input int ut = 0, input bit utk = 1'b0);
    redir_valid = rv;
    redir_line  = LW'(rl);
    deq_num     = 2'(dq);
    upd_en      = ue;
    upd_line    = LW'(ul);
    upd_target  = LW'(ut);
    upd_taken   = utk;
    model_step(rv, rl, dq, ue, ul, ut, utk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ld_en = 1'b0; ld_line = '0; ld_bundle0 = '0; ld_bundle1 = '0;
    ld_target = '0; ld_taken = 1'b0;
    upd_en = 1'b0; upd_line = '0; upd_target = '0; upd_taken = 1'b0;
    redir_valid = 1'b0; redir_line = '0; deq_num = '0;

    // program: 3 -> 10 and 12 -> 2 taken; line 5 holds a not-taken target
    for (int i = 0; i < NL; i++) begin
      m_tgt[i] = 0;
      m_tk[i]  = 1'b0;
    end
    m_tgt[3] = 10; m_tk[3] = 1'b1;
    m_tgt[12] = 2; m_tk[12] = 1'b1;
    m_tgt[5] = 17;

    @(negedge clk);
    for (int i = 0; i < NL; i++) begin
      ld_en = 1'b1;
      ld_line = LW'(i);
      ld_bundle0 = bval(i, 0);
      ld_bundle1 = bval(i, 1);
      ld_target = LW'(m_tgt[i]);
      ld_taken = m_tk[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk(q_count == 4'd0, "R1", "count in reset", BW'(q_count), BW'(0));
    chk(fetch_addr == '0, "R1", "fetch address in reset", BW'(fetch_addr), BW'(0));

    m_pc = 0;
    mcnt = 0;
    rst = 1'b0;

    for (int r = 0; r < NROWS; r++) begin
      tick(STIM[r][7], int'(STIM[r][6:2]), int'(STIM[r][1:0]));
      if (r == 0)
        chk(head0_addr == '0, "R1", "first line after reset", BW'(head0_addr), BW'(0));
      if (r == 5) begin
        // R5: queue full after four pushes, fetch parked on line 10
        chk(q_count == 4'd8, "R5", "full count", BW'(q_count), BW'(8));
        chk(fetch_addr == AW'(320), "R5", "held address", BW'(fetch_addr), BW'(320));
      end
      if (r == 15 || r == 29) begin
        // R8: redirect flushes and overrides
        chk(q_count == 4'd0, "R8", "flush count", BW'(q_count), BW'(0));
        chk(fetch_addr == AW'(STIM[r][6:2] * 32), "R8", "redirect address",
            BW'(fetch_addr), BW'(STIM[r][6:2] * 32));
      end
    end

    // R9: retarget line 9 while fetch is parked on it, then drain
    tick(1'b0, 0, 0, 1'b1, 9, 20, 1'b1);
    tick(1'b0, 0, 0);
    tick(1'b0, 0, 2);
    tick(1'b0, 0, 2);
    chk(fetch_addr == AW'(640), "R9", "updated target used",
        BW'(fetch_addr), BW'(640));
    tick(1'b0, 0, 2);
    tick(1'b0, 0, 2);
    tick(1'b0, 0, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
    $finish;
  end
endmodule